// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit resolves one operand of a 16-bit two-operand processor. It takes the addressing-mode field of the operand, the base register number, that register's current value, an optional extension word and a byte/word flag. From these it works out how the operand is reached. The operand may be a register value or an immediate value, or it may sit in memory at a computed effective address. The unit also reports whether an extension word must be fetched and how far the program counter moves to skip it. For autoincrement it gives the updated base-register value to write back.

A source operand is described by a 2-bit mode field. A destination operand is described by a 1-bit mode field. The `isDst` input picks which field applies, and the other field has no effect. Some register numbers turn a mode into a special case. Register 0, the program counter, makes indexed mode symbolic and autoincrement mode immediate. Register 2 makes indexed mode absolute: the extension word is then the whole address. Register 1, the stack pointer, always steps by 2.

A request is presented with `reqValid` high for one clock cycle. All results appear in registers on the following cycle, marked by `outValid`.

Top module: `opAddrUnit`

## Requirements
- R1: After reset, and until the first request, `outValid`, `needExt`, `isMem` and `wbEn` are 0 and `pcAdv` is 0.
- R2: Mode 0 (register): `isMem`=0, `needExt`=0, `wbEn`=0, and `opVal` equals `regVal`.
- R3: Mode 1 with a register other than 2 (indexed; symbolic when the register is 0): `needExt`=1, `isMem`=1, `wbEn`=0, and `effAddr` = (`regVal` + `extWord`) mod 2^16.
- R4: Mode 1 with register 2 (absolute): `needExt`=1, `isMem`=1, `wbEn`=0, and `effAddr` = `extWord`.
- R5: Source mode 2 (indirect): `isMem`=1, `needExt`=0, `wbEn`=0, and `effAddr` = `regVal`.
- R6: Source mode 3 with a register other than 0 (autoincrement): `isMem`=1, `needExt`=0, `effAddr` = `regVal` (the value before the increment), `wbEn`=1, `wbReg` = `regNum`, and `wbVal` = `regVal` + step mod 2^16. The step is 1 when `byteAcc`=1 and 2 when `byteAcc`=0.
- R7: For autoincrement on register 1, the step is 2 even when `byteAcc`=1.
- R8: Source mode 3 with register 0 (immediate): `needExt`=1, `isMem`=0, `wbEn`=0, and `opVal` = `extWord`.
- R9: With `isDst`=1, the mode is taken from `modeDst` alone: 0 acts as source mode 0 and 1 acts as source mode 1, including the register-0 and register-2 cases. `modeSrc` has no effect, and no write-back is ever requested.
- R10: `pcAdv` is 2 whenever `needExt`=1 and 0 otherwise.
- R11: Results appear exactly one cycle after a cycle with `reqValid`=1. In a cycle after `reqValid`=0, `outValid`=0 and `wbEn`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe for one operand |
| isDst | input | 1 | 1 selects the destination mode field |
| modeSrc | input | 2 | Source addressing mode |
| modeDst | input | 1 | Destination addressing mode |
| regNum | input | 4 | Base register number |
| regVal | input | 16 | Current value of the base register |
| extWord | input | 16 | Extension word following the instruction |
| byteAcc | input | 1 | 1 for a byte access, 0 for a word access |
| outValid | output | 1 | Results valid this cycle |
| needExt | output | 1 | An extension word is consumed |
| isMem | output | 1 | The operand lives in memory at effAddr |
| effAddr | output | 16 | Effective memory address |
| opVal | output | 16 | Register or immediate operand value |
| pcAdv | output | 2 | Program counter advance for the extension word |
| wbEn | output | 1 | Base-register write-back request |
| wbReg | output | 4 | Register to write back |
| wbVal | output | 16 | Value to write back |

## Verification
In autoincrement mode, two results come out in the same cycle: the memory address and the base-register write-back. The address must carry the base value from before the increment, and the write-back must carry the incremented value. The bench provokes this by sweeping every register with both access sizes and with base values near the top of the address range, which makes the increment wrap. For each case it compares `effAddr` against `regVal` and `wbVal` against the arithmetically wrapped sum, and it checks that the step for register 1 stays at 2.

// File: rtl/oamPkg.sv
package oamPkg;
  typedef enum logic [1:0] {
    MODE_REG  = 2'b00,
    MODE_IDX  = 2'b01,
    MODE_IND  = 2'b10,
    MODE_INC  = 2'b11
  } oamMode_e;

  typedef struct packed {
    logic useExt;
    logic useMem;
    logic addBase;
    logic zeroBase;
    logic postInc;
    logic immOp;
    logic forceWord;
  } oamStrobe_t;
endpackage

// File: rtl/oamCtrl.sv
module oamCtrl
  import oamPkg::*;
#(
  parameter int REG_W   = 4,
  parameter int PC_IDX  = 0,
  parameter int SP_IDX  = 1,
  parameter int ABS_IDX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             isDst,
  input  logic [1:0]       modeSrc,
  input  logic             modeDst,
  input  logic [REG_W-1:0] regNum,
  output oamStrobe_t       strobe,
  output logic             outValid
);
  localparam logic [REG_W-1:0] PcReg  = REG_W'(PC_IDX);
  localparam logic [REG_W-1:0] SpReg  = REG_W'(SP_IDX);
  localparam logic [REG_W-1:0] AbsReg = REG_W'(ABS_IDX);

  oamMode_e effMode;
  logic     isPc;

  assign effMode = isDst ? oamMode_e'({1'b0, modeDst}) : oamMode_e'(modeSrc);
  assign isPc    = (regNum == PcReg);

  always_comb begin
    strobe           = '0;
    strobe.forceWord = isPc || (regNum == SpReg);
    unique case (effMode)
      MODE_REG: ;
      MODE_IDX: begin
        strobe.useExt   = 1'b1;
        strobe.useMem   = 1'b1;
        strobe.addBase  = 1'b1;
        strobe.zeroBase = (regNum == AbsReg);
      end
      MODE_IND: strobe.useMem = 1'b1;
      MODE_INC: begin
        if (isPc) begin
          strobe.useExt = 1'b1;
          strobe.immOp  = 1'b1;
        end else begin
          strobe.useMem  = 1'b1;
          strobe.postInc = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid));

  p_dst_no_inc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isDst) |-> !strobe.postInc);
endmodule

// File: rtl/oamDatapath.sv
module oamDatapath
  import oamPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  oamStrobe_t        strobe,
  input  logic              byteAcc,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] extWord,
  output logic              needExt,
  output logic              isMem,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] opVal,
  output logic [1:0]        pcAdv,
  output logic              wbEn,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbVal
);
  localparam logic [DATA_W-1:0] StepByte = DATA_W'(1);
  localparam logic [DATA_W-1:0] StepWord = DATA_W'(2);

  logic [DATA_W-1:0] baseSel, addrNext, stepSel, incNext, opNext;

  assign baseSel  = strobe.zeroBase ? '0 : regVal;
  assign addrNext = strobe.addBase ? (baseSel + extWord) : regVal;
  assign stepSel  = (byteAcc && !strobe.forceWord) ? StepByte : StepWord;
  assign incNext  = regVal + stepSel;
  assign opNext   = strobe.immOp ? extWord : regVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      needExt <= 1'b0;
      isMem   <= 1'b0;
      effAddr <= '0;
      opVal   <= '0;
      pcAdv   <= 2'd0;
      wbEn    <= 1'b0;
      wbReg   <= '0;
      wbVal   <= '0;
    end else if (load) begin
      needExt <= strobe.useExt;
      isMem   <= strobe.useMem;
      effAddr <= addrNext;
      opVal   <= opNext;
      pcAdv   <= strobe.useExt ? 2'd2 : 2'd0;
      wbEn    <= strobe.postInc;
      wbReg   <= regNum;
      wbVal   <= incNext;
    end else begin
      needExt <= 1'b0;
      isMem   <= 1'b0;
      pcAdv   <= 2'd0;
      wbEn    <= 1'b0;
    end
  end

  p_step_size_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> ((DATA_W'(wbVal - effAddr) == StepByte) || (DATA_W'(wbVal - effAddr) == StepWord)));

  p_sp_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && wbReg == REG_W'(1)) |-> (DATA_W'(wbVal - effAddr) == StepWord));

  p_imm_no_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
    (needExt && !isMem) |-> !wbEn);

  p_inc_no_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (isMem && !needExt));
endmodule

// File: rtl/opAddrUnit.sv
module opAddrUnit
  import oamPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_N   = 16,
  parameter int PC_IDX  = 0,
  parameter int SP_IDX  = 1,
  parameter int ABS_IDX = 2,
  localparam int REG_W  = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              isDst,
  input  logic [1:0]        modeSrc,
  input  logic              modeDst,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] extWord,
  input  logic              byteAcc,
  output logic              outValid,
  output logic              needExt,
  output logic              isMem,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] opVal,
  output logic [1:0]        pcAdv,
  output logic              wbEn,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbVal
);
  oamStrobe_t strobe;

  oamCtrl #(
    .REG_W(REG_W), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX), .ABS_IDX(ABS_IDX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isDst(isDst),
    .modeSrc(modeSrc), .modeDst(modeDst), .regNum(regNum),
    .strobe(strobe), .outValid(outValid)
  );

  oamDatapath #(
    .DATA_W(DATA_W), .REG_W(REG_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .load(reqValid), .strobe(strobe),
    .byteAcc(byteAcc), .regNum(regNum), .regVal(regVal), .extWord(extWord),
    .needExt(needExt), .isMem(isMem), .effAddr(effAddr), .opVal(opVal),
    .pcAdv(pcAdv), .wbEn(wbEn), .wbReg(wbReg), .wbVal(wbVal)
  );

  p_wb_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> outValid);

  p_ext_adv_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (needExt == (pcAdv != 2'd0)));
endmodule

// File: tb/test_opAddrUnit.sv
module test_opAddrUnit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        isDst = 1'b0;
  logic [1:0]  modeSrc = 2'd0;
  logic        modeDst = 1'b0;
  logic [3:0]  regNum = 4'd0;
  logic [15:0] regVal = 16'd0;
  logic [15:0] extWord = 16'd0;
  logic        byteAcc = 1'b0;
  logic        outValid, needExt, isMem, wbEn;
  logic [15:0] effAddr, opVal, wbVal;
  logic [1:0]  pcAdv;
  logic [3:0]  wbReg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opAddrUnit i_opAddrUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isDst(isDst),
    .modeSrc(modeSrc), .modeDst(modeDst), .regNum(regNum), .regVal(regVal),
    .extWord(extWord), .byteAcc(byteAcc), .outValid(outValid),
    .needExt(needExt), .isMem(isMem), .effAddr(effAddr), .opVal(opVal),
    .pcAdv(pcAdv), .wbEn(wbEn), .wbReg(wbReg), .wbVal(wbVal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runVec(input bit dst, input int ms, input int md, input int rn,
                        input bit bt, input logic [15:0] rv, input logic [15:0] xw);
    int em;
    string tg;
    logic [15:0] step;
    @(negedge clk);
    reqValid = 1'b1; isDst = dst; modeSrc = 2'(ms); modeDst = md[0];
    regNum = 4'(rn); byteAcc = bt; regVal = rv; extWord = xw;
    @(negedge clk);
    reqValid = 1'b0;
    em = dst ? md : ms;
    chk("R11 outValid", 32'(outValid), 32'd1);
    case (em)
      0: begin
        tg = dst ? "R9 R2 dst reg" : "R2 reg";
        chk(tg, {needExt, isMem, wbEn}, 3'b000);
        chk(tg, 32'(opVal), 32'(rv));
      end
      1: begin
        if (rn == 2) begin
          tg = dst ? "R9 R4 dst abs" : "R4 abs";
          chk(tg, 32'(effAddr), 32'(xw));
        end else begin
          tg = dst ? "R9 R3 dst idx" : "R3 idx";
          chk(tg, 32'(effAddr), 32'(16'(rv + xw)));
        end
        chk(tg, {needExt, isMem, wbEn}, 3'b110);
      end
      2: begin
        chk("R5 ind", {needExt, isMem, wbEn}, 3'b010);
        chk("R5 ind addr", 32'(effAddr), 32'(rv));
      end
      default: begin
        if (rn == 0) begin
          chk("R8 imm", {needExt, isMem, wbEn}, 3'b100);
          chk("R8 imm val", 32'(opVal), 32'(xw));
        end else begin
          step = (bt && rn != 1) ? 16'd1 : 16'd2;
          tg = (rn == 1) ? "R7 sp inc" : "R6 inc";
          chk(tg, {needExt, isMem, wbEn}, 3'b011);
          chk(tg, 32'(effAddr), 32'(rv));
          chk(tg, 32'(wbReg), 32'(rn));
          chk(tg, 32'(wbVal), 32'(16'(rv + step)));
        end
      end
    endcase
    chk("R10 pcAdv", 32'(pcAdv), needExt ? 32'd2 : 32'd0);
  endtask

  initial begin
    logic [15:0] rvs [3];
    logic [15:0] xws [3];
    rvs[0] = 16'h1234; rvs[1] = 16'hFFFF; rvs[2] = 16'hFFFE;
    xws[0] = 16'h0100; xws[1] = 16'h0003; xws[2] = 16'hFF02;
    repeat (3) @(negedge clk);
    chk("R1 reset", {outValid, needExt, isMem, wbEn, pcAdv}, 6'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {outValid, needExt, isMem, wbEn, pcAdv}, 6'b0);
    for (int d = 0; d < 2; d++)
      for (int ms = 0; ms < 4; ms++)
        for (int md = 0; md < 2; md++) begin
          if (d == 0 && md == 1) continue;
          for (int rn = 0; rn < 16; rn++)
            for (int bt = 0; bt < 2; bt++)
              for (int k = 0; k < 3; k++)
                runVec(d[0], ms, md, rn, bt[0], rvs[k], xws[k]);
        end
    @(negedge clk);
    chk("R11 idle no valid", 32'(outValid), 32'd0);
    chk("R11 idle no wb", 32'(wbEn), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule